// File: doc/BRIEF.md
# Stalling Sum-of-Squares Register Slave

This block is a memory-mapped slave with a fixed-latency arithmetic job behind it. Software writes two unsigned 16-bit operands into their own registers, then writes a start command to a control register. The block then computes the sum of the squares of the operands in a 13-cycle pipeline and stores the result in a result register. If software reads the result register while a job is still running, the read is held with `waitrequest` until the new result has been stored. A blocking read issued straight after the start command therefore always returns the fresh value and never the previous one.

The bus has one clock and word addresses. The encoding is 0 = operand A, 1 = operand B, 2 = control, 3 = result. Back-pressure works one way only. While `waitrequest` is high the master keeps `read` and `address` unchanged. The read completes in the first cycle in which `waitrequest` is low, and `readdata` is valid in that cycle. Writes and all reads other than a result read during a job complete in the cycle they are presented.

Top module: `sumsq_accel_slave`

## Requirements
- R1: After reset, reads of A, B, control and result all return 0 with no wait state.
- R2: A write to address 0 (A) or 1 (B) stores `writedata[15:0]` and ignores the upper bits. A read returns the operand zero-extended to 32 bits.
- R3: A write to address 2 with bit 0 set, while idle, starts a job. From the next cycle a control read returns bit 0 = 1 (busy), and all other bits read 0. A control write with bit 0 clear does nothing.
- R4: A job yields (A*A + B*B) mod 2^32, using the operand values held at the start edge.
- R5: The result register takes its new value exactly 13 clock edges after the edge that accepted the start. Busy reads 1 for exactly 13 cycles.
- R6: A result read (address 3) during busy sees `waitrequest` high until the cycle after the result is stored. It then completes with the new value. A read presented 1+k cycles after the start cycle stalls for 13-k cycles.
- R7: Writes, and reads of addresses 0 to 2, never see `waitrequest` high.
- R8: A start write while busy is ignored. The job in flight keeps its operands and its completion time, and no second job follows.
- R9: Writes to A or B during a job update those registers but do not change the result in flight.
- R10: The result register holds its value until the next job completes.
- R11: A new start is accepted in the first idle cycle after a job ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| address | input | 2 | Word address of the register |
| read | input | 1 | Read request, held while waitrequest is high |
| write | input | 1 | Write request |
| writedata | input | 32 | Write data |
| readdata | output | 32 | Read data, valid when read is high and waitrequest is low |
| waitrequest | output | 1 | Stall for a result read during a job |

## Verification
The bench sweeps 64 operand pairs, including 0, 1, 0x8000 and 0xFFFF. For each pair it issues the result read in the cycle right after the start and requires exactly 13 stall cycles and the exact wrapped sum. A design that let the read through early would return the previous result, and one with a latency off by one would show 12 or 14 stalls. Delayed reads check that the stall shrinks by the delay and vanishes at 13 cycles. Further checks cover a start during a job, operand writes during a job, and a start in the first idle cycle. These expose a pipeline that restarts, one that reads live operand registers, and one that swallows a start on the completion boundary.

// File: rtl/sumsq_pkg.sv
package sumsq_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_OPA    = 2'd0,
    SEL_OPB    = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_RESULT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wr_a;
    logic wr_b;
    logic start;
    logic rd_result;
  } strobe_t;
endpackage

// File: rtl/sumsq_decode.sv
module sumsq_decode
  import sumsq_pkg::*;
(
  input  logic     read,
  input  logic     write,
  input  reg_sel_e sel,
  input  logic     go_bit,
  input  logic     busy,
  output strobe_t  stb
);
  always_comb begin
    stb           = '0;
    stb.wr_a      = write && (sel == SEL_OPA);
    stb.wr_b      = write && (sel == SEL_OPB);
    // a start needs bit 0 set and an idle pipeline
    stb.start     = write && (sel == SEL_CTRL) && go_bit && !busy;
    stb.rd_result = read && (sel == SEL_RESULT);
  end
endmodule

// File: rtl/sumsq_pipe.sv
// Fixed-latency a*a + b*b. Stage 0 captures, stage 1 squares,
// stage 2 adds, stages 3..LAT-1 delay. LAT must be at least 3.
module sumsq_pipe #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned RES_W = 32,
  parameter int unsigned LAT   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OP_W-1:0]  a_in,
  input  logic [OP_W-1:0]  b_in,
  output logic             done,
  output logic             busy,
  output logic [RES_W-1:0] sum_out
);
  localparam int unsigned SQ_W = 2 * OP_W;

  logic [LAT-1:0]   vld;
  logic [OP_W-1:0]  cap_a, cap_b;
  logic [SQ_W-1:0]  sq_a, sq_b;
  logic [RES_W-1:0] stg [2:LAT-1];
  logic [RES_W-1:0] wrap_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else        vld <= {vld[LAT-2:0], start};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (start) begin
      cap_a <= a_in;
      cap_b <= b_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_a <= '0;
      sq_b <= '0;
    end else if (vld[0]) begin
      sq_a <= SQ_W'(cap_a) * SQ_W'(cap_a);
      sq_b <= SQ_W'(cap_b) * SQ_W'(cap_b);
    end
  end

  assign wrap_sum = RES_W'({1'b0, sq_a} + {1'b0, sq_b});

  always_ff @(posedge clk) begin
    if (!rst_n)      stg[2] <= '0;
    else if (vld[1]) stg[2] <= wrap_sum;
  end

  for (genvar i = 3; i < LAT; i++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n)        stg[i] <= '0;
      else if (vld[i-1]) stg[i] <= stg[i-1];
    end
  end

  assign sum_out = stg[LAT-1];
  assign done    = vld[LAT-1];
  assign busy    = |vld;
endmodule

// File: rtl/sumsq_regbank.sv
module sumsq_regbank
  import sumsq_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  reg_sel_e         sel,
  input  logic [OP_W-1:0]  wdata,
  input  logic             done,
  input  logic [BUS_W-1:0] sum_in,
  input  logic             busy,
  output logic [OP_W-1:0]  opa,
  output logic [OP_W-1:0]  opb,
  output logic [BUS_W-1:0] result_q,
  output logic [BUS_W-1:0] readdata,
  output logic             waitrequest
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa <= '0;
      opb <= '0;
    end else begin
      if (stb.wr_a) opa <= wdata;
      if (stb.wr_b) opb <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    result_q <= '0;
    else if (done) result_q <= sum_in;
  end

  // only a result read during a job is held back
  assign waitrequest = stb.rd_result && busy;

  always_comb begin
    unique case (sel)
      SEL_OPA:  readdata = BUS_W'(opa);
      SEL_OPB:  readdata = BUS_W'(opb);
      SEL_CTRL: readdata = BUS_W'(busy);
      default:  readdata = result_q;
    endcase
  end
endmodule

// File: rtl/sumsq_accel_slave.sv
module sumsq_accel_slave #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned BUS_W = 32,
  parameter int unsigned LAT   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       address,
  input  logic             read,
  input  logic             write,
  input  logic [BUS_W-1:0] writedata,
  output logic [BUS_W-1:0] readdata,
  output logic             waitrequest
);
  import sumsq_pkg::*;

  reg_sel_e        sel;
  strobe_t         stb;
  logic            busy;
  logic            done;
  logic [OP_W-1:0] opa, opb;
  logic [BUS_W-1:0] sum_w;
  logic [BUS_W-1:0] result_q;
  logic            unused_wd;

  assign sel       = reg_sel_e'(address);
  assign unused_wd = ^writedata[BUS_W-1:OP_W];

  sumsq_decode u_dec (
    .read   (read),
    .write  (write),
    .sel    (sel),
    .go_bit (writedata[0]),
    .busy   (busy),
    .stb    (stb)
  );

  sumsq_pipe #(.OP_W(OP_W), .RES_W(BUS_W), .LAT(LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (stb.start),
    .a_in    (opa),
    .b_in    (opb),
    .done    (done),
    .busy    (busy),
    .sum_out (sum_w)
  );

  sumsq_regbank #(.OP_W(OP_W), .BUS_W(BUS_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .sel         (sel),
    .wdata       (writedata[OP_W-1:0]),
    .done        (done),
    .sum_in      (sum_w),
    .busy        (busy),
    .opa         (opa),
    .opb         (opb),
    .result_q    (result_q),
    .readdata    (readdata),
    .waitrequest (waitrequest)
  );
endmodule

// File: rtl/sumsq_accel_chk.sv
module sumsq_accel_chk #(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned LAT   = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             read,
  input logic             write,
  input logic [1:0]       address,
  input logic             wd0,
  input logic             waitrequest,
  input logic             busy,
  input logic [BUS_W-1:0] result_q
);
  localparam int unsigned CW = $clog2(LAT + 2);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == CW'(LAT));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (write && address == 2'd2 && wd0 && !busy) |=> busy);

  assert_no_write_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    write |-> !waitrequest);

  assert_wait_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    waitrequest |-> (read && address == 2'd3));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_q) |-> ($past(busy) && !busy));
endmodule

bind sumsq_accel_slave sumsq_accel_chk #(.BUS_W(BUS_W), .LAT(LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .read        (read),
  .write       (write),
  .address     (address),
  .wd0         (writedata[0]),
  .waitrequest (waitrequest),
  .busy        (busy),
  .result_q    (result_q)
);

// File: tb/tb_sumsq_accel_slave.sv
module tb_sumsq_accel_slave;
  localparam int LAT = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  address = '0;
  logic        read = 1'b0;
  logic        write = 1'b0;
  logic [31:0] writedata = '0;
  logic [31:0] readdata;
  logic        waitrequest;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sumsq_accel_slave dut (
    .clk(clk), .rst_n(rst_n), .address(address), .read(read),
    .write(write), .writedata(writedata), .readdata(readdata),
    .waitrequest(waitrequest)
  );

  function automatic logic [31:0] expect_sum(logic [15:0] a, logic [15:0] b);
    logic [63:0] t;
    t = 64'(a) * 64'(a) + 64'(b) * 64'(b);
    return t[31:0];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] a, logic [31:0] d, output bit stalled);
    @(negedge clk);
    address = a; writedata = d; write = 1'b1;
    #1 stalled = waitrequest;
    @(posedge clk);
    #1 write = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bit s;
    do_write(a, d, s);
    check(!s, "R7", 32'(s), 0);
  endtask

  task automatic do_read(logic [1:0] a, output logic [31:0] d, output int stalls);
    @(negedge clk);
    address = a; read = 1'b1;
    stalls = 0;
    #1;
    while (waitrequest && stalls < 1000) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    d = readdata;
    @(posedge clk);
    #1 read = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    int st;
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
             16'h00FF, 16'h1234, 16'h8000, 16'hFFFF};

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    for (int r = 0; r < 4; r++) begin
      do_read(2'(r), d, st);
      check(d == 0 && st == 0, "R1", d, 0);
    end

    // R2 operand write, upper bits dropped, zero-extended readback
    wr(2'd0, 32'hABCD_1357);
    do_read(2'd0, d, st);
    check(d == 32'h0000_1357, "R2", d, 32'h1357);
    wr(2'd1, 32'hFFFF_8001);
    do_read(2'd1, d, st);
    check(d == 32'h0000_8001, "R2", d, 32'h8001);

    // R3 control write with bit 0 clear does nothing
    wr(2'd2, 32'hFFFF_FFFE);
    do_read(2'd2, d, st);
    check(d == 0 && st == 0, "R3", d, 0);
    do_read(2'd3, d, st);
    check(d == 0 && st == 0, "R3", d, 0);

    // sweep: R4 value, R6 stall of 13 for a read right after start
    foreach (vals[i]) begin
      foreach (vals[j]) begin
        wr(2'd0, {16'hA5A5, vals[i]});
        wr(2'd1, {16'h5A5A, vals[j]});
        wr(2'd2, 32'd1);
        do_read(2'd3, d, st);
        check(st == LAT, "R6", st, LAT);
        check(d == expect_sum(vals[i], vals[j]), "R4", d, expect_sum(vals[i], vals[j]));
      end
    end

    // R3 busy bit right after start, R7 other reads unstalled, R5 busy length
    wr(2'd0, 32'd7);
    wr(2'd1, 32'd9);
    wr(2'd2, 32'd1);
    do_read(2'd2, d, st);
    check(d == 1 && st == 0, "R3", d, 1);
    do_read(2'd0, d, st);
    check(st == 0 && d == 7, "R7", st, 0);
    idle(10);                     // read now at cycle C+13: last busy cycle
    do_read(2'd2, d, st);
    check(d == 1, "R5", d, 1);
    do_read(2'd2, d, st);         // cycle C+14: idle
    check(d == 0, "R5", d, 0);
    do_read(2'd3, d, st);
    check(d == 130 && st == 0, "R5", d, 130);

    // R6 delayed reads: k=5 gives 8 stalls, k=13 gives none
    wr(2'd0, 32'd100);
    wr(2'd2, 32'd1);
    idle(5);
    do_read(2'd3, d, st);
    check(st == LAT - 5, "R6", st, LAT - 5);
    check(d == 32'd10081, "R6", d, 10081);
    wr(2'd0, 32'd3);
    wr(2'd2, 32'd1);
    idle(13);
    do_read(2'd3, d, st);
    check(st == 0 && d == 32'd90, "R6", st, 0);

    // R8 start during busy ignored; R9 operand write during busy
    wr(2'd0, 32'd11);
    wr(2'd1, 32'd12);
    wr(2'd2, 32'd1);              // cycle C
    wr(2'd0, 32'd500);            // C+1
    wr(2'd2, 32'd1);              // C+2, ignored
    do_read(2'd3, d, st);         // C+3
    check(st == LAT - 2, "R8", st, LAT - 2);
    check(d == 32'd265, "R9", d, 265);
    do_read(2'd2, d, st);
    check(d == 0, "R8", d, 0);
    do_read(2'd0, d, st);
    check(d == 32'd500, "R9", d, 500);

    // R10 result held while idle
    prev = d;
    idle(20);
    do_read(2'd3, d, st);
    check(d == 32'd265 && st == 0, "R10", d, 265);
    do_read(2'd3, d, st);
    check(d == 32'd265 && st == 0, "R10", d, 265);

    // R11 back-to-back: start in first idle cycle
    wr(2'd0, 32'd2);
    wr(2'd1, 32'd3);
    wr(2'd2, 32'd1);              // C
    wr(2'd0, 32'd20);             // C+1
    wr(2'd1, 32'd30);             // C+2
    idle(11);
    wr(2'd2, 32'd1);              // C+14
    do_read(2'd3, d, st);
    check(st == LAT, "R11", st, LAT);
    check(d == 32'd1300, "R11", d, 1300);

    // R4 wrap: both operands at maximum
    wr(2'd0, 32'hFFFF);
    wr(2'd1, 32'hFFFF);
    wr(2'd2, 32'd1);
    do_read(2'd3, d, st);
    check(d == 32'hFFFC_0002, "R4", d, 32'hFFFC0002);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule